// File: doc/BRIEF.md
# Quadrature Carrier Up-Mixer with Phase-Accumulator Oscillator

This block shifts a complex baseband stream up to an intermediate frequency. Every clock it takes one signed I sample and one signed Q sample. It multiplies them by the cosine and sine of a carrier angle, and it returns two signed output channels that together form a single-sideband complex up-conversion. A phase accumulator produces the carrier angle. Each clock the accumulator adds a programmable tuning word, and a programmable phase offset is added on top. One control bit flips the sign of the Q terms, which picks the upper or the lower sideband. A second control bit switches the whole mixer off so that the samples go through unchanged.

Software programs the oscillator through a byte-wide write port. The tuning word and the phase offset are each spread over several byte slots. The lower bytes wait in a holding register. The value takes effect only when its top byte is written, so a frequency or phase update is never seen half-applied. The cosine and sine values come from a quarter-wave table. The table is generated at elaboration time, and its symmetry is used to cover all four quadrants.

Top module: `nco_qmix`

## Requirements
- R1: While reset is high, both outputs read 0. After reset the oscillator is disabled, and the tuning word, phase offset and sign bit are all 0.
- R2: Write addresses 0 to 3 carry the 32-bit tuning word, least significant byte at address 0. Writes to addresses 0, 1 and 2 alone leave the active tuning word unchanged. The write to address 3 loads all 32 bits together.
- R3: Write addresses 4 and 5 carry the 16-bit phase offset, low byte at address 4. The offset changes only when address 5 is written.
- R4: Address 6 is the control byte. Bit 0 enables the oscillator and bit 1 selects the inverted sine sign. A control write applies to the samples taken from the next clock edge onward. Writes to address 7 have no effect.
- R5: While the oscillator is disabled, out_a equals in_i and out_b equals in_q exactly, and the accumulator is held at 0.
- R6: While enabled, the accumulator adds the tuning word on every clock. The carrier angle is 2π(p+0.5)/4096, where p is bits 15:4 of the sum of accumulator bits 31:16 and the phase offset, taken modulo 2^16.
- R7: With the sign bit clear, out_a = I·cos − Q·sin and out_b = I·sin + Q·cos. The carrier amplitude is 8191/8192, and each output is within 2 LSB of the ideal rounded value.
- R8: With the sign bit set, out_a = I·cos + Q·sin and out_b = I·sin − Q·cos, with the same accuracy as R7.
- R9: Results that fall outside the signed 14-bit range saturate to 8191 or −8192. They do not wrap.
- R10: A sample taken at one clock edge reaches the outputs after the fourth rising edge, counting that edge. The mixed path and the bypass path have the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register byte address |
| wr_data | input | 8 | Register write byte |
| in_i | input | 14 | Baseband in-phase sample, two's complement |
| in_q | input | 14 | Baseband quadrature sample, two's complement |
| out_a | output | 14 | First mixed output channel, two's complement |
| out_b | output | 14 | Second mixed output channel, two's complement |

## Verification
The assertions check three things on every cycle. A partial write must never disturb the active tuning word or phase offset. The accumulator must step by exactly the tuning word while enabled and hold zero while disabled. In bypass, the outputs must repeat the inputs from four cycles earlier. The sine and cosine values, the sideband sign, rounding and saturation can only be shown by the bench scenarios. In those scenarios the outputs are compared against a floating-point carrier model that tracks the accumulator, the staged register writes and the control changes, both in directed corner cases (a quarter-turn offset, full-scale inputs at 45 degrees, partial tuning writes) and in long random runs.

// File: rtl/nco_qmix.sv
`timescale 1ns/1ps
module nco_qmix #(
  parameter int DATA_W = 14,
  parameter int FTW_W  = 32,
  parameter int PH_W   = 16,
  parameter int LUT_AW = 10,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic signed [DATA_W-1:0] out_a,
  output logic signed [DATA_W-1:0] out_b
);
  localparam int FB     = FTW_W / 8;
  localparam int PB     = PH_W / 8;
  localparam int A_PMSB = FB + PB - 1;
  localparam int A_CTL  = FB + PB;
  localparam int ANG_W  = LUT_AW + 2;
  localparam int LUT_N  = 1 << LUT_AW;
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = DATA_W - 1;
  localparam int AMP    = (1 << (DATA_W - 1)) - 1;

  // sin(pi*(2k+1)/(4*LUT_N)) scaled to AMP, fixed-point Taylor series in Q30
  function automatic int qsin(input int k);
    longint x, term, t1, t2, acc;
    x = (64'sd3373259426 * longint'(2 * k + 1)) / longint'(4 * LUT_N);
    term = x;
    acc  = x;
    for (int n = 1; n < 9; n++) begin
      t1   = (term * x) / (64'sd1 <<< 30);
      t2   = (t1 * x) / (64'sd1 <<< 30);
      term = -t2 / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return int'((acc * longint'(AMP) + (64'sd1 <<< 29)) / (64'sd1 <<< 30));
  endfunction

  logic [DATA_W-2:0] lut [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    localparam int V = qsin(k);
    assign lut[k] = (DATA_W-1)'(V);
  end

  // register file: staged low bytes, atomic commit on the top byte
  logic [FTW_W-1:0] ftw, acc;
  logic [FTW_W-9:0] ftw_sh;
  logic [PH_W-1:0]  ph;
  logic [PH_W-9:0]  ph_sh;
  logic             en_q, sg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw <= '0; ftw_sh <= '0; ph <= '0; ph_sh <= '0;
      en_q <= 1'b0; sg_q <= 1'b0;
    end else if (wr_en) begin
      for (int b = 0; b < FB - 1; b++)
        if (wr_addr == ADDR_W'(b)) ftw_sh[8*b +: 8] <= wr_data;
      if (wr_addr == ADDR_W'(FB - 1)) ftw <= {wr_data, ftw_sh};
      for (int b = 0; b < PB - 1; b++)
        if (wr_addr == ADDR_W'(FB + b)) ph_sh[8*b +: 8] <= wr_data;
      if (wr_addr == ADDR_W'(A_PMSB)) ph <= {wr_data, ph_sh};
      if (wr_addr == ADDR_W'(A_CTL)) begin
        en_q <= wr_data[0];
        sg_q <= wr_data[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_q) acc <= '0;
    else              acc <= acc + ftw;
  end

  logic [PH_W-1:0] ph_sum;
  assign ph_sum = acc[FTW_W-1 -: PH_W] + ph;

  // quadrant folding
  logic [ANG_W-1:0]         ang1;
  logic [1:0]               qd_s, qd_c;
  logic [LUT_AW-1:0]        ix, ix_s, ix_c;
  logic signed [DATA_W-1:0] mag_s, mag_c, sn_w, cs_w;

  assign qd_s  = ang1[ANG_W-1 -: 2];
  assign qd_c  = qd_s + 2'd1;
  assign ix    = ang1[LUT_AW-1:0];
  assign ix_s  = qd_s[0] ? ~ix : ix;
  assign ix_c  = qd_c[0] ? ~ix : ix;
  assign mag_s = {1'b0, lut[ix_s]};
  assign mag_c = {1'b0, lut[ix_c]};
  assign sn_w  = qd_s[1] ? -mag_s : mag_s;
  assign cs_w  = qd_c[1] ? -mag_c : mag_c;

  logic signed [DATA_W-1:0] i1, q1, i2, q2, i3, q3, sn2, cs2;
  logic signed [PROD_W-1:0] pic, pqs, pis, pqc;
  logic                     en1, en2, en3, sg1, sg2, sg3;

  logic signed [SUM_W-1:0] sum_a, sum_b;
  assign sum_a = sg3 ? ({pic[PROD_W-1], pic} + {pqs[PROD_W-1], pqs})
                     : ({pic[PROD_W-1], pic} - {pqs[PROD_W-1], pqs});
  assign sum_b = sg3 ? ({pis[PROD_W-1], pis} - {pqc[PROD_W-1], pqc})
                     : ({pis[PROD_W-1], pis} + {pqc[PROD_W-1], pqc});

  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] r;
    r = (v + $signed(SUM_W'(1 << (SHIFT - 1)))) >>> SHIFT;
    if (r[SUM_W-1:DATA_W-1] == '0 || r[SUM_W-1:DATA_W-1] == '1)
      return r[DATA_W-1:0];
    return r[SUM_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ang1 <= '0; i1 <= '0; q1 <= '0; en1 <= 1'b0; sg1 <= 1'b0;
      sn2 <= '0; cs2 <= '0; i2 <= '0; q2 <= '0; en2 <= 1'b0; sg2 <= 1'b0;
      pic <= '0; pqs <= '0; pis <= '0; pqc <= '0;
      i3 <= '0; q3 <= '0; en3 <= 1'b0; sg3 <= 1'b0;
      out_a <= '0; out_b <= '0;
    end else begin
      ang1 <= ph_sum[PH_W-1 -: ANG_W];
      i1 <= in_i; q1 <= in_q; en1 <= en_q; sg1 <= sg_q;
      sn2 <= sn_w; cs2 <= cs_w;
      i2 <= i1; q2 <= q1; en2 <= en1; sg2 <= sg1;
      pic <= i2 * cs2; pqs <= q2 * sn2;
      pis <= i2 * sn2; pqc <= q2 * cs2;
      i3 <= i2; q3 <= q2; en3 <= en2; sg3 <= sg2;
      out_a <= en3 ? rnd_sat(sum_a) : i3;
      out_b <= en3 ? rnd_sat(sum_b) : q3;
    end
  end

  // assertions
  logic [2:0] live;
  always_ff @(posedge clk) begin
    if (rst)               live <= '0;
    else if (live != 3'd4) live <= live + 3'd1;
  end

  assert_ftw_atomic_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ADDR_W'(FB - 1)) |=> $stable(ftw));

  assert_phase_atomic_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ADDR_W'(A_PMSB)) |=> $stable(ph));

  assert_bypass_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (live == 3'd4 && !$past(en_q, 4)) |->
      (out_a == $past(in_i, 4) && out_b == $past(in_q, 4)));

  assert_acc_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> acc == '0);

  assert_acc_step_R6: assert property (@(posedge clk) disable iff (rst)
    en_q |=> acc == $past(acc) + $past(ftw));
endmodule

// File: tb/sim_nco_qmix.sv
`timescale 1ns/1ps
module sim_nco_qmix;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic signed [13:0] in_i = '0, in_q = '0;
  logic signed [13:0] out_a, out_b;

  always #2.5 clk = ~clk;

  nco_qmix u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
               .in_i(in_i), .in_q(in_q), .out_a(out_a), .out_b(out_b));

  int errors = 0, checks = 0;
  bit done = 0;

  bit [31:0] m_acc, m_ftw;
  bit [23:0] m_fsh;
  bit [15:0] m_ph;
  bit [7:0]  m_psh;
  bit        m_en, m_sg;

  int    xa[4], xb[4], xt[4];
  bit    xv[4];
  string xs[4];

  task automatic chk(input string tag, input string what, input int got, input int exp, input int tol);
    int d;
    checks++;
    d = got - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (tol %0d)", tag, what, got, exp, tol);
    end
  endtask

  function automatic int clip(input real v);
    int r;
    r = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    if (r > 8191) r = 8191;
    if (r < -8192) r = -8192;
    return r;
  endfunction

  function automatic void mix(input int i, input int q, input bit [15:0] p, input bit neg,
                              output int a, output int b);
    real ang, c, s, sg;
    ang = 2.0 * PI * (real'(int'(p >> 4)) + 0.5) / 4096.0;
    c  = 8191.0 * $cos(ang) / 8192.0;
    s  = 8191.0 * $sin(ang) / 8192.0;
    sg = neg ? -1.0 : 1.0;
    a = clip(real'(i) * c - sg * real'(q) * s);
    b = clip(real'(i) * s + sg * real'(q) * c);
  endfunction

  function automatic int rs();
    return int'($urandom_range(0, 16383)) - 8192;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(input int i, input int q, input bit we, input int adr, input int dat,
                      input string tag);
    int ea, eb, tl;
    bit [15:0] p;
    bit [31:0] acc_n;
    if (xv[3]) begin
      chk(xs[3], "out_a", int'(out_a), xa[3], xt[3]);
      chk(xs[3], "out_b", int'(out_b), xb[3], xt[3]);
    end
    for (int k = 3; k > 0; k--) begin
      xa[k] = xa[k-1]; xb[k] = xb[k-1]; xt[k] = xt[k-1]; xv[k] = xv[k-1]; xs[k] = xs[k-1];
    end
    in_i = 14'(i); in_q = 14'(q);
    wr_en = we; wr_addr = 3'(adr); wr_data = 8'(dat);
    if (m_en) begin
      p = m_acc[31:16] + m_ph;
      mix(i, q, p, m_sg, ea, eb);
      tl = 2;
    end else begin
      ea = i; eb = q; tl = 0;
    end
    xa[0] = ea; xb[0] = eb; xt[0] = tl; xv[0] = 1'b1; xs[0] = tag;
    acc_n = m_en ? m_acc + m_ftw : 32'd0;
    if (we) begin
      case (adr)
        0, 1, 2: m_fsh[8*adr +: 8] = 8'(dat);
        3: m_ftw = {8'(dat), m_fsh};
        4: m_psh = 8'(dat);
        5: m_ph  = {8'(dat), m_psh};
        6: begin m_en = dat[0]; m_sg = dat[1]; end
        default: ;
      endcase
    end
    m_acc = acc_n;
    @(negedge clk);
  endtask

  task automatic wr(input int adr, input int dat, input string tag);
    step(rs(), rs(), 1'b1, adr, dat, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) xv[k] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_a in reset", int'(out_a), 0, 0);
    chk("R1", "out_b in reset", int'(out_b), 0, 0);
    rst = 1'b0;

    // R1 disabled after reset, R5 bypass, R10 latency
    for (int n = 0; n < 12; n++) step(rs(), rs(), 1'b0, 0, 0, "R1 R5 R10");
    step(rs(), rs(), 1'b1, 7, 8'hff, "R4 addr7 ignored");
    for (int n = 0; n < 6; n++) step(rs(), rs(), 1'b0, 0, 0, "R4 R5");

    // R3 quarter-turn phase offset with zero tuning word
    wr(4, 8'h00, "R3");
    wr(5, 8'h40, "R3");
    wr(6, 8'h01, "R4");
    for (int n = 0; n < 8; n++) step(4000, 0, 1'b0, 0, 0, "R3 R7");
    for (int n = 0; n < 10; n++) step(rs(), rs(), 1'b0, 0, 0, "R7");

    // R2 partial tuning-word writes must not move the carrier
    wr(0, 8'h35, "R2");
    wr(1, 8'h9a, "R2");
    wr(2, 8'h21, "R2");
    for (int n = 0; n < 8; n++) step(rs(), rs(), 1'b0, 0, 0, "R2 held");
    wr(3, 8'h04, "R2 R6");
    for (int n = 0; n < 40; n++) step(rs(), rs(), 1'b0, 0, 0, "R6 R7");
    wr(4, 8'h77, "R3 partial");
    for (int n = 0; n < 6; n++) step(rs(), rs(), 1'b0, 0, 0, "R3 held");

    // R8 lower sideband
    wr(6, 8'h03, "R4 R8");
    for (int n = 0; n < 40; n++) step(rs(), rs(), 1'b0, 0, 0, "R8");

    // R9 saturation at 45 degrees, fixed carrier
    wr(0, 0, "R9"); wr(1, 0, "R9"); wr(2, 0, "R9"); wr(3, 0, "R9");
    wr(4, 8'h00, "R9"); wr(5, 8'h20, "R9"); wr(6, 8'h01, "R9");
    for (int n = 0; n < 6; n++) step(8191, -8192, 1'b0, 0, 0, "R9 high");
    for (int n = 0; n < 6; n++) step(-8192, 8191, 1'b0, 0, 0, "R9 low");
    wr(6, 8'h03, "R9 R8");
    for (int n = 0; n < 6; n++) step(8191, 8191, 1'b0, 0, 0, "R9 R8");

    // R4 per-sample enable switching
    wr(6, 8'h00, "R4");
    step(rs(), rs(), 1'b0, 0, 0, "R4 R5");
    wr(6, 8'h01, "R4");
    step(rs(), rs(), 1'b0, 0, 0, "R4 R7");
    wr(6, 8'h00, "R4 R10");
    for (int n = 0; n < 6; n++) step(rs(), rs(), 1'b0, 0, 0, "R4 R5 R10");

    // random mix of samples and register writes
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        int a;
        a = int'($urandom_range(0, 7));
        if (a == 6) step(rs(), rs(), 1'b1, a, int'($urandom_range(0, 3)) | ($urandom_range(0, 3) != 0 ? 1 : 0), "R4 R5 R8");
        else step(rs(), rs(), 1'b1, a, int'($urandom_range(0, 255)), "R2 R3 R6");
      end else begin
        step(rs(), rs(), 1'b0, 0, 0, "R6 R7 R8 R9");
      end
    end
    for (int n = 0; n < 5; n++) step(0, 0, 1'b0, 0, 0, "R10 drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule